// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Line Transmitter

This block turns a stream of stereo audio samples into a single self-clocking serial line. Time on the line is divided into 32-bit subframes that alternate between the left channel (A) and the right channel (B). One A/B pair is a frame, and a fixed number of frames (192 by default) forms a block. Each subframe opens with a four-bit sync pattern. The rest of the subframe carries a 24-bit audio word passed through a programmable bit mask, a validity flag, one user bit, one channel-status bit and an even-parity bit. The user and status bits come from per-channel bit banks that hold one bit for each frame of the block.

Every data bit is sent as two half-cells in biphase-mark form. The sync patterns are fixed half-cell sequences that break that rule on purpose, so a receiver can find subframe boundaries. A half-cell lasts a parameterised number of clock cycles.

The sample source sees a request strobe at the start of each subframe. It answers with one valid-qualified sample, which is sent in the following subframe. If no answer arrives in time, the block sends a zero word and marks it invalid. A block-start strobe marks the first half-cell of each block.

Top module: `spdif_bmc_tx`

## Requirements
- R1: While `en_i` is low, or during reset, `line_o`, `req_o` and `blk_start_o` are all 0, and the sequencer returns to the first subframe of a block. Dropping `en_i` clears them at the next clock edge.
- R2: `line_o` changes only on half-cell boundaries, and each half-cell lasts exactly `HALF_CLKS` clock cycles.
- R3: A block holds 2*`FRAMES` subframes, ordered A, B, A, B and so on. `blk_start_o` is high for one clock, in the same cycle that the first half-cell of frame 0 channel A appears on `line_o`.
- R4: Slot bits 0–3 are sent as 8 half-cells (first half-cell first). The patterns are 11101000 for the block-start subframe, 11100010 for other channel-A subframes and 11100100 for channel B. Each pattern is XORed with the line level just before the subframe.
- R5: Slot bits 4–31 each take two half-cells. The line toggles at the start of every bit cell and toggles again mid-cell when the bit is 1.
- R6: Slot bits 4–27 hold the accepted sample ANDed with `mask_i`, sample bit 0 in slot bit 4. The mask in force at the start of the subframe is the one used.
- R7: Slot bit 28 is 0 when a sample was accepted for that subframe. When no sample was accepted, the audio field is all zero and bit 28 is 1.
- R8: Slot bit 29 is the user-bank bit and slot bit 30 is the status-bank bit of the subframe's channel. Both banks are indexed by the frame number, which runs 0 to `FRAMES`-1 within a block.
- R9: Slot bit 31 makes the number of ones in slot bits 4–31 even, so the line level at the end of every subframe equals the level at its start.
- R10: `req_o` pulses for one clock at the start of every subframe. The first cycle with `smp_valid_i` high after that pulse and before the next one supplies the sample for the next subframe. A valid sample offered when none is pending is ignored.
- R11: After `en_i` rises, the first subframe begins `HALF_CLKS` cycles later as a block-start subframe. It carries no sample (zero audio, bit 28 set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Encoder clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmit enable; low holds the block idle |
| mask_i | input | 24 | Bit mask ANDed with the audio word |
| smp_valid_i | input | 1 | Sample offered this cycle |
| smp_data_i | input | 24 | Offered audio sample |
| cs_a_i | input | FRAMES | Channel-status bank, channel A, bit = frame |
| cs_b_i | input | FRAMES | Channel-status bank, channel B, bit = frame |
| ud_a_i | input | FRAMES | User-data bank, channel A, bit = frame |
| ud_b_i | input | FRAMES | User-data bank, channel B, bit = frame |
| line_o | output | 1 | Biphase-mark encoded serial line |
| blk_start_o | output | 1 | One-clock strobe at block start |
| req_o | output | 1 | One-clock sample request per subframe |

## Verification
The bench builds the block with `FRAMES` = 4 and `HALF_CLKS` = 2, so one block is only 8 subframes (1024 clocks). This makes it possible to cover every subframe position of four complete blocks: each frame index, both channels and the wrap back to frame 0. A different mask and a different set of bank contents are applied in each block. The bench decodes every half-cell of every subframe independently and checks the result. A missing sample every fifth subframe, a spurious second offer in each subframe, and an enable drop followed by a restart exercise the validity, handshake and restart rules.

// File: rtl/spdif_pkg.sv
package spdif_pkg;

    localparam int SLOT_BITS = 32;
    localparam int AUDIO_W   = 24;
    localparam int PRE_BITS  = 4;
    localparam int AUD_LSB   = 4;
    localparam int VAL_POS   = 28;
    localparam int USR_POS   = 29;
    localparam int CST_POS   = 30;
    localparam int PAR_POS   = 31;
    localparam int BIT_W     = $clog2(SLOT_BITS);

    typedef enum logic [1:0] {
        SYNC_BLOCK = 2'd0,
        SYNC_CHA   = 2'd1,
        SYNC_CHB   = 2'd2
    } sync_kind_e;

    // Half-cell sequences for a line that sat low before the subframe;
    // MSB is emitted first.
    function automatic logic [7:0] sync_halves(input sync_kind_e kind);
        case (kind)
            SYNC_BLOCK: sync_halves = 8'b1110_1000;
            SYNC_CHA:   sync_halves = 8'b1110_0010;
            default:    sync_halves = 8'b1110_0100;
        endcase
    endfunction

endpackage

// File: rtl/spdif_half_tick.sv
module spdif_half_tick #(
    parameter int HALF_CLKS = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tick_o
);

    generate
        if (HALF_CLKS <= 1) begin : g_direct
            assign tick_o = en_i;
        end else begin : g_count
            localparam int CW = $clog2(HALF_CLKS);
            localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!en_i) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign tick_o = en_i && (cnt_q == LAST);

            // R2
            tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o)
                else $error("half-cell strobes on adjacent cycles");
        end
    endgenerate

endmodule

// File: rtl/spdif_slot_word.sv
module spdif_slot_word
    import spdif_pkg::*;
(
    input  logic [AUDIO_W-1:0]   sample_i,
    input  logic [AUDIO_W-1:0]   mask_i,
    input  logic                 have_i,
    input  logic                 usr_i,
    input  logic                 cst_i,
    output logic [SLOT_BITS-1:0] word_o
);

    logic [SLOT_BITS-1:0] w;

    always_comb begin
        w = '0;
        if (have_i) begin
            w[AUD_LSB +: AUDIO_W] = sample_i & mask_i;
        end
        w[VAL_POS] = !have_i;
        w[USR_POS] = usr_i;
        w[CST_POS] = cst_i;
        w[PAR_POS] = ^w[PAR_POS-1:AUD_LSB];
        word_o     = w;
    end

endmodule

// File: rtl/spdif_bmc_line.sv
module spdif_bmc_line
    import spdif_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [BIT_W-1:0] bit_i,
    input  logic             half_i,
    input  sync_kind_e       kind_i,
    input  logic             data_i,
    output logic             line_o
);

    typedef struct packed {
        logic line;
        logic pol;
        logic started;
    } line_state_t;

    line_state_t d, q;

    logic       sub_start;
    logic [2:0] half_idx;
    logic [7:0] pattern;

    assign sub_start = (bit_i == '0) && !half_i;
    assign half_idx  = {bit_i[1:0], half_i};
    assign pattern   = sync_halves(kind_i);

    always_comb begin
        logic ref_lvl;
        d       = q;
        ref_lvl = sub_start ? q.line : q.pol;
        if (!en_i) begin
            d = '0;
        end else if (tick_i) begin
            if (bit_i < BIT_W'(PRE_BITS)) begin
                d.line = pattern[3'd7 - half_idx] ^ ref_lvl;
                if (sub_start) begin
                    d.pol     = q.line;
                    d.started = 1'b1;
                end
            end else if (!half_i) begin
                d.line = !q.line;
            end else begin
                d.line = q.line ^ data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.line;

    // R2
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tick_i) |=> $stable(line_o))
        else $error("line moved inside a half-cell");

    // R9
    level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && tick_i && sub_start && q.started) |-> (q.line == q.pol))
        else $error("subframe ended at a different level than it began");

endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx
    import spdif_pkg::*;
#(
    parameter int FRAMES    = 192,
    parameter int HALF_CLKS = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [23:0]        mask_i,
    input  logic               smp_valid_i,
    input  logic [23:0]        smp_data_i,
    input  logic [FRAMES-1:0]  cs_a_i,
    input  logic [FRAMES-1:0]  cs_b_i,
    input  logic [FRAMES-1:0]  ud_a_i,
    input  logic [FRAMES-1:0]  ud_b_i,
    output logic               line_o,
    output logic               blk_start_o,
    output logic               req_o
);

    localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam logic [FW-1:0]    LAST_FRAME = FW'(FRAMES - 1);
    localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(SLOT_BITS - 1);

    typedef struct packed {
        logic [FW-1:0]        frame;
        logic                 chan;
        logic [BIT_W-1:0]     bitn;
        logic                 half;
        logic [SLOT_BITS-1:0] word;
        logic [AUDIO_W-1:0]   hold;
        logic                 have;
        logic                 pend;
        logic                 blk;
        logic                 req;
    } seq_state_t;

    seq_state_t d, q;

    logic                 tick;
    logic                 usr_bit;
    logic                 cst_bit;
    logic [SLOT_BITS-1:0] new_word;
    sync_kind_e           kind;

    spdif_half_tick #(
        .HALF_CLKS (HALF_CLKS)
    ) i_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .tick_o (tick)
    );

    assign usr_bit = q.chan ? ud_b_i[q.frame] : ud_a_i[q.frame];
    assign cst_bit = q.chan ? cs_b_i[q.frame] : cs_a_i[q.frame];

    spdif_slot_word i_word (
        .sample_i (q.hold),
        .mask_i   (mask_i),
        .have_i   (q.have),
        .usr_i    (usr_bit),
        .cst_i    (cst_bit),
        .word_o   (new_word)
    );

    always_comb begin
        if (q.chan) begin
            kind = SYNC_CHB;
        end else if (q.frame == '0) begin
            kind = SYNC_BLOCK;
        end else begin
            kind = SYNC_CHA;
        end
    end

    always_comb begin
        logic start;
        d     = q;
        d.blk = 1'b0;
        d.req = 1'b0;
        start = (q.bitn == '0) && !q.half;
        if (!en_i) begin
            d = '0;
        end else begin
            if (smp_valid_i && q.pend) begin
                d.hold = smp_data_i;
                d.have = 1'b1;
                d.pend = 1'b0;
            end
            if (tick) begin
                if (start) begin
                    d.word = new_word;
                    d.have = 1'b0;
                    d.pend = 1'b1;
                    d.req  = 1'b1;
                    d.blk  = (q.frame == '0) && !q.chan;
                end
                if (!q.half) begin
                    d.half = 1'b1;
                end else begin
                    d.half = 1'b0;
                    if (q.bitn == LAST_BIT) begin
                        d.bitn = '0;
                        if (q.chan) begin
                            d.chan  = 1'b0;
                            d.frame = (q.frame == LAST_FRAME) ? '0 : q.frame + 1'b1;
                        end else begin
                            d.chan = 1'b1;
                        end
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    spdif_bmc_line i_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .tick_i (tick),
        .bit_i  (q.bitn),
        .half_i (q.half),
        .kind_i (kind),
        .data_i (q.word[q.bitn]),
        .line_o (line_o)
    );

    assign blk_start_o = q.blk;
    assign req_o       = q.req;

    // R1
    idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!line_o && !req_o && !blk_start_o))
        else $error("outputs active while disabled");

    // R3
    blk_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blk_start_o |-> (q.frame == '0 && !q.chan && q.bitn == '0 && q.half))
        else $error("block strobe away from frame 0 channel A");

    // R10
    req_blk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blk_start_o |-> req_o)
        else $error("block start without a subframe request");

    // R10
    take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.have) |-> $past(smp_valid_i))
        else $error("sample taken without an offer");

endmodule

// File: tb/test_spdif_bmc_tx.sv
module test_spdif_bmc_tx;

    localparam int FR   = 4;
    localparam int HALF = 2;
    localparam int SUBS = 2 * FR;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          en_i = 1'b0;
    logic [23:0]   mask_i = '0;
    logic          smp_valid_i = 1'b0;
    logic [23:0]   smp_data_i = '0;
    logic [FR-1:0] cs_a_i = '0;
    logic [FR-1:0] cs_b_i = '0;
    logic [FR-1:0] ud_a_i = '0;
    logic [FR-1:0] ud_b_i = '0;
    logic          line_o;
    logic          blk_start_o;
    logic          req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    spdif_bmc_tx #(
        .FRAMES    (FR),
        .HALF_CLKS (HALF)
    ) i_spdif_bmc_tx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .mask_i      (mask_i),
        .smp_valid_i (smp_valid_i),
        .smp_data_i  (smp_data_i),
        .cs_a_i      (cs_a_i),
        .cs_b_i      (cs_b_i),
        .ud_a_i      (ud_a_i),
        .ud_b_i      (ud_b_i),
        .line_o      (line_o),
        .blk_start_o (blk_start_o),
        .req_o       (req_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] data_for(input int s);
        return 24'(s * 24'h0B1D3 + 24'h5A3C1) ^ 24'hA50F33;
    endfunction

    function automatic logic [23:0] mask_for(input int b);
        case (b % 4)
            0:       return 24'hFFFFFF;
            1:       return 24'hFFFF00;
            2:       return 24'h00FFFF;
            default: return 24'hF0F0F0;
        endcase
    endfunction

    function automatic logic [FR-1:0] csa_for(input int b); return FR'(b * 5 + 3); endfunction
    function automatic logic [FR-1:0] csb_for(input int b); return FR'(b * 3 + 9); endfunction
    function automatic logic [FR-1:0] uda_for(input int b); return FR'(b * 7 + 1); endfunction
    function automatic logic [FR-1:0] udb_for(input int b); return ~FR'(b * 7 + 1); endfunction

    task automatic apply_cfg(input int s);
        int b;
        b      = s / SUBS;
        mask_i = mask_for(b);
        cs_a_i = csa_for(b);
        cs_b_i = csb_for(b);
        ud_a_i = uda_for(b);
        ud_b_i = udb_for(b);
    endtask

    task automatic run_subframes(input int n);
        logic        prev;
        logic        sup_prev;
        logic [23:0] dat_prev;
        int          waitc;
        prev     = 1'b0;
        sup_prev = 1'b0;
        dat_prev = '0;
        apply_cfg(0);
        @(negedge clk_i);
        en_i  = 1'b1;
        waitc = 0;
        do begin
            @(negedge clk_i);
            waitc++;
        end while (!req_o && waitc < 50);
        // R11: first subframe starts HALF_CLKS cycles after enable
        check(waitc == HALF, "R11 start delay", waitc, HALF);
        for (int s = 0; s < n; s++) begin
            logic [63:0]  h;
            logic [31:0]  bits;
            logic [7:0]   pre_exp;
            logic [7:0]   pre_act;
            logic [23:0]  aud_exp;
            logic         stable;
            logic         strobe_ok;
            logic         bmc_ok;
            logic         lvl;
            logic         sup;
            logic [23:0]  dat;
            int           fr;
            int           ch;
            int           b;
            h         = '0;
            bits      = '0;
            stable    = 1'b1;
            strobe_ok = 1'b1;
            sup       = (s % 5) != 3;
            dat       = data_for(s);
            fr        = (s / 2) % FR;
            ch        = s % 2;
            b         = s / SUBS;
            for (int c = 0; c < 64 * HALF; c++) begin
                if (!(s == 0 && c == 0)) @(negedge clk_i);
                if (c % HALF == 0) h[c / HALF] = line_o;
                else if (line_o != h[c / HALF]) stable = 1'b0;
                if (c == 0) begin
                    // R10: request at every subframe start
                    check(req_o == 1'b1, "R10 request strobe", req_o, 1);
                    // R3: block strobe only on first subframe of a block
                    check(blk_start_o == (s % SUBS == 0), "R3 block strobe",
                          blk_start_o, (s % SUBS == 0));
                end else if (req_o || blk_start_o) begin
                    strobe_ok = 1'b0;
                end
                if (c == 1 && sup) begin
                    smp_valid_i = 1'b1;
                    smp_data_i  = dat;
                end
                if (c == 2) smp_valid_i = 1'b0;
                if (c == 5 && sup) begin
                    smp_valid_i = 1'b1;
                    smp_data_i  = ~dat;
                end
                if (c == 6) smp_valid_i = 1'b0;
                if (c == 10) apply_cfg(s + 1);
            end
            // R2
            check(stable, "R2 half-cell hold", stable, 1);
            check(strobe_ok, "R10 single strobe per subframe", strobe_ok, 1);
            // R4
            if (s % SUBS == 0)  pre_exp = 8'b1110_1000;
            else if (ch == 0)   pre_exp = 8'b1110_0010;
            else                pre_exp = 8'b1110_0100;
            pre_exp = pre_exp ^ {8{prev}};
            for (int k = 0; k < 8; k++) pre_act[7 - k] = h[k];
            check(pre_act == pre_exp, "R4 sync pattern", pre_act, pre_exp);
            // R5
            bmc_ok = 1'b1;
            lvl    = h[7];
            for (int bt = 4; bt < 32; bt++) begin
                if (h[2 * bt] == lvl) bmc_ok = 1'b0;
                bits[bt] = h[2 * bt] ^ h[2 * bt + 1];
                lvl      = h[2 * bt + 1];
            end
            check(bmc_ok, "R5 cell-start toggle", bmc_ok, 1);
            // R6 (R10: the first offer is the one sent, the second ignored)
            aud_exp = sup_prev ? (dat_prev & mask_for(b)) : 24'h0;
            check(bits[27:4] == aud_exp, "R6 audio field", bits[27:4], aud_exp);
            // R7
            check(bits[28] == !sup_prev, "R7 validity bit", bits[28], !sup_prev);
            // R8
            if (ch == 0) begin
                check(bits[29] == uda_for(b)[fr], "R8 user bit A", bits[29], uda_for(b)[fr]);
                check(bits[30] == csa_for(b)[fr], "R8 status bit A", bits[30], csa_for(b)[fr]);
            end else begin
                check(bits[29] == udb_for(b)[fr], "R8 user bit B", bits[29], udb_for(b)[fr]);
                check(bits[30] == csb_for(b)[fr], "R8 status bit B", bits[30], csb_for(b)[fr]);
            end
            // R9
            check((^bits[31:4]) == 1'b0, "R9 even parity", bits[31:4], 0);
            check(h[63] == prev, "R9 end level", h[63], prev);
            prev     = h[63];
            sup_prev = sup;
            dat_prev = dat;
        end
    endtask

    initial begin : watchdog
        for (int i = 0; i < 60000; i++) begin
            @(posedge clk_i);
            if (done) disable watchdog;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: reset state
        check(line_o == 1'b0 && req_o == 1'b0 && blk_start_o == 1'b0,
              "R1 reset outputs", {line_o, req_o, blk_start_o}, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        run_subframes(4 * SUBS);
        @(negedge clk_i);
        en_i = 1'b0;
        @(negedge clk_i);
        for (int i = 0; i < 6; i++) begin
            // R1: disabled outputs stay idle
            check(line_o == 1'b0 && req_o == 1'b0 && blk_start_o == 1'b0,
                  "R1 disabled outputs", {line_o, req_o, blk_start_o}, 0);
            @(negedge clk_i);
        end
        // R11: restart from a block start with no sample
        run_subframes(12);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule